// File: doc/BRIEF.md
# Oscillator Trim Calibration Loop

This block closes a frequency loop around a trimmable local oscillator. It runs entirely on the local clock and receives a slower reference clock as an asynchronous input. The goal is a local frequency of three times the reference. The trim code can pull the oscillator across a wide span, from a nominal rate near 8 MHz up to about 14.3 MHz.

The reference is brought into the local domain through a two-stage synchronizer, and its rising edges are detected there. A measurement window opens only on a detected reference edge, so the two clocks are aligned when counting starts. The window closes when an 8-bit reference edge counter wraps, which is 256 reference cycles at the defaults. The number of local cycles in that span is compared with a target of 768. A count below the tolerance band raises the 8-bit trim code by one, and a count above the band lowers it by one. The code saturates at both ends. Windows run back to back.

A lock flag rises after two consecutive windows inside the band. It falls on any window outside the band. A one-cycle start pulse drops the lock, reloads the trim code with 128 and re-arms the measurement.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, trim_o is TRIM_RST (default 128), lock_o is 0 and win_done_o is 0.
- R2: A window begins at a detected reference rising edge and ends at the 2**REF_BITS-th detected rising edge after it (256 by default). At that point count_o reports the number of local cycles between the two edges, and win_done_o pulses high for exactly one cycle. The next window begins at that same closing edge.
- R3: When a window's count is below RATIO*2**REF_BITS - TOL (default 768 - 2), trim_o increases by one in the same cycle that win_done_o is high.
- R4: When a window's count is above RATIO*2**REF_BITS + TOL, trim_o decreases by one in the same cycle that win_done_o is high.
- R5: A count inside the band (both limits inclusive) leaves trim_o unchanged. trim_o never changes in a cycle where win_done_o is low, except after start_i.
- R6: trim_o saturates: it stays at 255 on a low count and stays at 0 on a high count.
- R7: lock_o rises with the second consecutive in-band window (LOCK_WINS, default 2). It falls with any out-of-band window, and it changes only in a cycle where win_done_o is high or after start_i.
- R8: A high start_i sets trim_o to TRIM_RST and lock_o to 0 on the next cycle and clears the in-band run. It discards the window in progress, so no win_done_o appears until a full window has been measured from the next detected reference edge.
- R9: Reference edges are detected only as low-to-high transitions after a two-flop synchronizer. The reference must stay high and low for at least one local cycle each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local (trimmed) oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Asynchronous reference clock |
| start_i | input | 1 | Restart calibration, one-cycle pulse |
| trim_o | output | TRIM_W | Oscillator trim code |
| lock_o | output | 1 | Frequency within tolerance |
| win_done_o | output | 1 | One-cycle strobe at each window result |
| count_o | output | CNT_W | Local cycle count of the last window |

## Verification
The bench generates a reference clock whose periods are whole numbers of local cycles. Within each group of 32 periods, a set number of periods are lengthened or shortened by one cycle. This makes every window total the target plus a chosen offset, and the offset is swept across both band edges. The sweep separates the increment, hold and decrement decisions exactly at the inclusive limits. Long runs at large offsets drive the code into both saturation ends. The start pulse is placed mid-run to show the reload, the dropped lock and the absence of a strobe from the discarded window. A constant-offset run at the start shows lock building over two windows.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  typedef enum logic {
    WIN_ARM  = 1'b0,
    WIN_MEAS = 1'b1
  } win_state_e;

  typedef enum logic [1:0] {
    CMP_LOW  = 2'd0,
    CMP_OK   = 2'd1,
    CMP_HIGH = 2'd2
  } cmp_e;

  function automatic cmp_e classify(input int unsigned cnt,
                                    input int unsigned lo,
                                    input int unsigned hi);
    if (cnt < lo)      return CMP_LOW;
    else if (cnt > hi) return CMP_HIGH;
    else               return CMP_OK;
  endfunction

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/win_counter.sv
module win_counter
  import osc_trim_pkg::*;
#(
  parameter int unsigned REF_BITS = 8,
  parameter int unsigned CNT_W    = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rise_i,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [REF_BITS-1:0] REF_LAST = '1;
  localparam logic [CNT_W-1:0]    LOC_MAX  = '1;

  win_state_e          st_q;
  logic [REF_BITS-1:0] ref_q;
  logic [CNT_W-1:0]    loc_q;
  logic [CNT_W-1:0]    loc_inc;

  assign loc_inc = (loc_q == LOC_MAX) ? loc_q : loc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WIN_ARM;
      ref_q  <= '0;
      loc_q  <= '0;
      done_o <= 1'b0;
      cnt_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        st_q  <= WIN_ARM;
        ref_q <= '0;
        loc_q <= '0;
      end else begin
        unique case (st_q)
          WIN_ARM: begin
            if (rise_i) begin
              st_q  <= WIN_MEAS;
              ref_q <= '0;
              loc_q <= '0;
            end
          end
          WIN_MEAS: begin
            loc_q <= loc_inc;
            if (rise_i) begin
              if (ref_q == REF_LAST) begin
                // closing edge also opens the next window
                done_o <= 1'b1;
                cnt_o  <= loc_inc;
                ref_q  <= '0;
                loc_q  <= '0;
              end else begin
                ref_q <= ref_q + 1'b1;
              end
            end
          end
          default: st_q <= WIN_ARM;
        endcase
      end
    end
  end
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned TRIM_W    = 8,
  parameter int unsigned TRIM_RST  = 128,
  parameter int unsigned TARGET    = 768,
  parameter int unsigned TOL       = 2,
  parameter int unsigned LOCK_WINS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              lock_o,
  output logic              upd_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int unsigned  LO     = TARGET - TOL;
  localparam int unsigned  HI     = TARGET + TOL;
  localparam int unsigned  GOOD_W = $clog2(LOCK_WINS + 1);
  localparam logic [TRIM_W-1:0] TRIM_MAX = '1;
  localparam logic [TRIM_W-1:0] TRIM_INI = TRIM_W'(TRIM_RST);
  localparam logic [GOOD_W-1:0] GOOD_LIM = GOOD_W'(LOCK_WINS);

  cmp_e              cmp;
  logic [GOOD_W-1:0] good_q;
  logic [GOOD_W-1:0] good_nx;

  assign cmp     = classify(int'(cnt_i), LO, HI);
  assign good_nx = (good_q == GOOD_LIM) ? good_q : good_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trim_o <= TRIM_INI;
      lock_o <= 1'b0;
      good_q <= '0;
      upd_o  <= 1'b0;
      cnt_o  <= '0;
    end else if (start_i) begin
      trim_o <= TRIM_INI;
      lock_o <= 1'b0;
      good_q <= '0;
      upd_o  <= 1'b0;
    end else begin
      upd_o <= done_i;
      if (done_i) begin
        cnt_o <= cnt_i;
        unique case (cmp)
          CMP_LOW: begin
            if (trim_o != TRIM_MAX) trim_o <= trim_o + 1'b1;
            good_q <= '0;
            lock_o <= 1'b0;
          end
          CMP_HIGH: begin
            if (trim_o != '0) trim_o <= trim_o - 1'b1;
            good_q <= '0;
            lock_o <= 1'b0;
          end
          default: begin
            good_q <= good_nx;
            lock_o <= (good_nx >= GOOD_LIM);
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/osc_trim_cal.sv
module osc_trim_cal #(
  parameter int unsigned REF_BITS    = 8,
  parameter int unsigned RATIO       = 3,
  parameter int unsigned TOL         = 2,
  parameter int unsigned TRIM_W      = 8,
  parameter int unsigned TRIM_RST    = 128,
  parameter int unsigned LOCK_WINS   = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = REF_BITS + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_clk_i,
  input  logic              start_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              lock_o,
  output logic              win_done_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int unsigned TARGET = RATIO << REF_BITS;

  logic             ref_rise;
  logic             meas_done;
  logic [CNT_W-1:0] meas_cnt;

  ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ref_clk_i),
    .rise_o (ref_rise)
  );

  win_counter #(.REF_BITS(REF_BITS), .CNT_W(CNT_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .rise_i (ref_rise),
    .done_o (meas_done),
    .cnt_o  (meas_cnt)
  );

  trim_ctrl #(
    .CNT_W(CNT_W), .TRIM_W(TRIM_W), .TRIM_RST(TRIM_RST),
    .TARGET(TARGET), .TOL(TOL), .LOCK_WINS(LOCK_WINS)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .done_i (meas_done),
    .cnt_i  (meas_cnt),
    .trim_o (trim_o),
    .lock_o (lock_o),
    .upd_o  (win_done_o),
    .cnt_o  (count_o)
  );
endmodule

// File: rtl/osc_trim_cal_chk.sv
module osc_trim_cal_chk #(
  parameter int unsigned REF_BITS = 8,
  parameter int unsigned RATIO    = 3,
  parameter int unsigned TOL      = 2,
  parameter int unsigned TRIM_W   = 8,
  parameter int unsigned CNT_W    = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [TRIM_W-1:0] trim_o,
  input logic              lock_o,
  input logic              win_done_o,
  input logic [CNT_W-1:0]  count_o
);
  localparam int unsigned LO = (RATIO << REF_BITS) - TOL;
  localparam int unsigned HI = (RATIO << REF_BITS) + TOL;
  localparam logic [TRIM_W-1:0] TMAX = '1;

  // R2
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done_o |=> !win_done_o);

  // R3
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_o && int'(count_o) < LO && $past(trim_o) != TMAX)
      |-> trim_o == $past(trim_o) + 1'b1);

  // R4
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_o && int'(count_o) > HI && $past(trim_o) != '0)
      |-> trim_o == $past(trim_o) - 1'b1);

  // R5
  trim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_done_o && !$past(start_i)) |-> $stable(trim_o));

  // R6
  trim_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_o && ($past(trim_o) == TMAX || $past(trim_o) == '0)
     && int'(count_o) < LO) |-> trim_o == TMAX || $past(trim_o) == '0);

  // R7
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_done_o && (int'(count_o) < LO || int'(count_o) > HI)) |-> !lock_o);

  // R7
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> win_done_o);

  // R8
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !lock_o && !win_done_o);
endmodule

bind osc_trim_cal osc_trim_cal_chk #(
  .REF_BITS(REF_BITS), .RATIO(RATIO), .TOL(TOL),
  .TRIM_W(TRIM_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .trim_o    (trim_o),
  .lock_o    (lock_o),
  .win_done_o(win_done_o),
  .count_o   (count_o)
);

// File: tb/osc_trim_cal_test.sv
module osc_trim_cal_test;
  localparam int CLK_PERIOD = 10;
  localparam int REF_BITS   = 5;
  localparam int NREF       = 1 << REF_BITS;
  localparam int RATIO      = 3;
  localparam int TOL        = 2;
  localparam int TARGET     = RATIO * NREF;
  localparam int CNT_W      = 12;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ref_clk_i = 1'b0;
  logic             start_i = 1'b0;
  logic [7:0]       trim_o;
  logic             lock_o;
  logic             win_done_o;
  logic [CNT_W-1:0] count_o;

  int total = 0;
  int bad   = 0;
  int dev   = 0;
  int exp_trim = 128;
  int exp_good = 0;
  bit done_flag = 0;

  osc_trim_cal #(.REF_BITS(REF_BITS), .RATIO(RATIO), .TOL(TOL),
                 .CNT_W(CNT_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_clk_i(ref_clk_i),
    .start_i(start_i), .trim_o(trim_o), .lock_o(lock_o),
    .win_done_o(win_done_o), .count_o(count_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference: base period RATIO cycles, first |dev| of each NREF periods +/-1
  initial begin
    @(negedge clk_i);
    forever begin
      for (int i = 0; i < NREF; i++) begin
        int len;
        len = RATIO;
        if (i < ((dev < 0) ? -dev : dev)) len = (dev < 0) ? RATIO - 1 : RATIO + 1;
        ref_clk_i = 1'b1;
        @(negedge clk_i);
        ref_clk_i = 1'b0;
        repeat (len - 1) @(negedge clk_i);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    do @(negedge clk_i); while (!win_done_o);
  endtask

  // n windows; first `skip` ones may mix two offsets, so their count is not checked
  task automatic run_windows(input int n, input int skip);
    for (int w = 0; w < n; w++) begin
      int c;
      wait_done();
      c = (w < skip) ? int'(count_o) : TARGET + dev;
      if (w >= skip) chk("R2 count", int'(count_o), c);
      if (c < TARGET - TOL) begin
        if (exp_trim < 255) exp_trim++;
        exp_good = 0;
      end else if (c > TARGET + TOL) begin
        if (exp_trim > 0) exp_trim--;
        exp_good = 0;
      end else if (exp_good < 2) exp_good++;
      chk((c < TARGET - TOL) ? "R3 trim up" : (c > TARGET + TOL) ? "R4 trim down" : "R5 trim hold",
          int'(trim_o), exp_trim);
      chk("R7 lock", int'(lock_o), (exp_good >= 2) ? 1 : 0);
      @(negedge clk_i);
      chk("R2 strobe one cycle", int'(win_done_o), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 trim", int'(trim_o), 128);
    chk("R1 lock", int'(lock_o), 0);
    chk("R1 strobe", int'(win_done_o), 0);
    rst_ni = 1'b1;

    // R7 R9: exact ratio builds lock over two windows
    dev = 0;
    run_windows(3, 0);

    // R3 R4 R5: sweep across both band limits
    for (int d = -6; d <= 6; d++) begin
      dev = d;
      run_windows(3, 1);
    end

    // R8: restart mid-run
    repeat (20) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R8 trim reload", int'(trim_o), 128);
    chk("R8 lock cleared", int'(lock_o), 0);
    exp_trim = 128;
    exp_good = 0;
    begin
      int seen = 0;
      for (int k = 0; k < TARGET - 6; k++) begin
        @(negedge clk_i);
        if (win_done_o) seen++;
      end
      chk("R8 no early strobe", seen, 0);
    end
    run_windows(2, 0);

    // R6: saturate high then low
    dev = -20;
    run_windows(140, 1);
    chk("R6 top saturation", int'(trim_o), 255);
    dev = 20;
    run_windows(270, 1);
    chk("R6 bottom saturation", int'(trim_o), 0);

    done_flag = 1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (150000) @(negedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule